// File: doc/BRIEF.md
# 8-bit ALU with Protected Status Flags

This block is the arithmetic and logic datapath of a small 8-bit controller, together with the status register it owns. Each cycle it may take one operation code. It also takes the accumulator value, a memory operand and the current carry, which is read from its own status register. From these it computes, within the same cycle, a result, a write-back strobe and a skip indication for conditional-skip instructions. The status register then takes the new flags on the next rising clock edge.

Software can read and write the status register over the data bus. Two power-management flags in it are shielded from such writes. They move only on four event inputs: power-up, watchdog clear, halt and watchdog overflow. The watchdog timer that produces these events is not part of this block. Nothing is saved automatically on interrupts or calls, so the surrounding core must save the status register itself if it needs to.

Top module: `alu8_status`

## Requirements
- R1: The status register has C at bit 0, AC at bit 1, Z at bit 2, OV at bit 3, the power-down flag at bit 4 and the timeout flag at bit 5. Bits 7 and 6 always read 0. An active-low reset clears the whole register.
- R2: ADD (code 0) gives a+b. ADC (code 1) gives a+b+C. Both write back and set C to the carry out of bit 7, AC to the carry out of bit 3, Z to result==0 and OV to signed overflow.
- R3: SUB (code 2) gives a-b. SBC (code 3) gives a-b-(1-C). Both write back and update all four low flags. C=1 and AC=1 mean that no borrow occurred, from bit 7 and from bit 3 respectively. OV is signed overflow and Z is result==0.
- R4: DAA (code 4) adjusts a. It first adds 06h if a[3:0]>9 or AC=1. It then adds 60h if the upper nibble of that sum is >9, or C=1, or that first add carried. C is set when either add carries out and is otherwise left unchanged. No other flag changes.
- R5: AND (5), OR (6) and XOR (7) combine a with b. CPL (8) gives ~b, INC (13) gives b+1 and DEC (14) gives b-1. All write back and change only Z.
- R6: RL (9) and RR (10) rotate b left or right by one bit and change no flag. RLC (11) and RRC (12) rotate b through C, and C receives the bit shifted out. The other flags are left unchanged.
- R7: SZ (15) raises skip when b==0, and SNZ (16) raises skip when b!=0; neither writes back. SIZ (17) and SDZ (18) write back b+1 or b-1 and raise skip when that value is 0. None of these four changes a flag.
- R8: A status write stores wr_data[3:0] into the four low flags and leaves bits 4 and 5 unchanged. When a write and a flag-changing operation fall in the same cycle, the write wins.
- R9: The power-down flag is cleared by power-up or watchdog clear. Otherwise HALT sets it, and otherwise it holds.
- R10: The timeout flag is cleared by power-up, watchdog clear or HALT. Otherwise watchdog overflow sets it, and otherwise it holds.
- R11: When op_valid is low, or the code is 19 to 31, there is no write-back, no skip and no change to any flag.
- R12: result_we is high exactly for a valid op whose code is 0 to 14, 17 or 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| opnd_a | input | 8 | Accumulator operand |
| opnd_b | input | 8 | Memory / second operand |
| st_wr_en | input | 1 | Data-bus write to the status register |
| st_wr_data | input | 8 | Data-bus write value |
| wdt_ovf | input | 1 | Watchdog overflow event |
| wdt_clr | input | 1 | Watchdog clear event |
| halt_ev | input | 1 | HALT executed |
| pwr_up | input | 1 | Power-up event |
| result | output | 8 | Operation result |
| result_we | output | 1 | Result is to be written back |
| skip | output | 1 | Skip the next instruction |
| status | output | 8 | Status register contents |

## Verification
The assertions check the following on every cycle: the two top bits stay zero; the two power-management flags hold, set or clear according to the event priorities; skip comes only from the four skip codes; the pure-test skips never write back; and idle, undefined and plain-rotate cycles leave the low flags untouched. The arithmetic itself can only be shown by the bench's scenarios. These cover the carries, borrows, signed overflow and decimal-adjust corners, the rotate-through-carry paths, and the write-over-operation priority. They compare results and flags against an independently written reference model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int NW  = DW / 2;
  localparam int OPW = 5;
  localparam int SW  = 8;
  localparam int ST_C   = 0;
  localparam int ST_AC  = 1;
  localparam int ST_Z   = 2;
  localparam int ST_OV  = 3;
  localparam int ST_PDF = 4;
  localparam int ST_TO  = 5;
  localparam int LOW_FLAGS = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11,
    OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15,
    OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] sum;
    logic          c;
    logic          ac;
    logic          ov;
  } addres_t;

  // Shared adder: subtraction passes ~y and a carry-in of 1 (no borrow).
  function automatic addres_t add_f(logic [DW-1:0] x, logic [DW-1:0] y, logic ci);
    logic [DW:0] full;
    logic [NW:0] half;
    addres_t     r;
    full  = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, ci};
    half  = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, ci};
    r.sum = full[DW-1:0];
    r.c   = full[DW];
    r.ac  = half[NW];
    r.ov  = (x[DW-1] == y[DW-1]) && (full[DW-1] != x[DW-1]);
    return r;
  endfunction

  // Decimal adjust: returns {carry, value}.
  function automatic logic [DW:0] daa_f(logic [DW-1:0] x, logic ac, logic c);
    logic        lo_fix, hi_fix;
    logic [DW:0] t, u;
    lo_fix = (x[NW-1:0] > 4'd9) || ac;
    t      = {1'b0, x} + (lo_fix ? 9'h006 : 9'h000);
    hi_fix = (t[DW-1:NW] > 4'd9) || c || t[DW];
    u      = {1'b0, t[DW-1:0]} + (hi_fix ? 9'h060 : 9'h000);
    return {c | t[DW] | u[DW], u[DW-1:0]};
  endfunction
endpackage

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic                 op_valid,
  input  logic [OPW-1:0]       op_code,
  input  logic [DW-1:0]        a,
  input  logic [DW-1:0]        b,
  input  logic                 c_in,
  input  logic                 ac_in,
  output logic [DW-1:0]        res,
  output logic                 we,
  output logic                 skip,
  output logic [LOW_FLAGS-1:0] fmask,
  output logic [LOW_FLAGS-1:0] fval
);
  addres_t       ar;
  logic [DW:0]   dj;
  logic [DW-1:0] b_inc, b_dec;
  alu_op_e       op;

  assign op    = alu_op_e'(op_code);
  assign b_inc = b + 1'b1;
  assign b_dec = b - 1'b1;
  assign dj    = daa_f(a, ac_in, c_in);

  always_comb begin
    case (op)
      OP_ADC:  ar = add_f(a, b, c_in);
      OP_SUB:  ar = add_f(a, ~b, 1'b1);
      OP_SBC:  ar = add_f(a, ~b, c_in);
      default: ar = add_f(a, b, 1'b0);
    endcase
  end

  always_comb begin
    res   = '0;
    we    = 1'b0;
    skip  = 1'b0;
    fmask = '0;
    fval  = '0;
    if (op_valid) begin
      unique case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
          res = ar.sum; we = 1'b1; fmask = '1;
          fval[ST_C] = ar.c; fval[ST_AC] = ar.ac;
          fval[ST_OV] = ar.ov; fval[ST_Z] = (ar.sum == '0);
        end
        OP_DAA: begin
          res = dj[DW-1:0]; we = 1'b1;
          fmask[ST_C] = 1'b1; fval[ST_C] = dj[DW];
        end
        OP_AND, OP_OR, OP_XOR, OP_CPL, OP_INC, OP_DEC: begin
          case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~b;
            OP_INC:  res = b_inc;
            default: res = b_dec;
          endcase
          we = 1'b1;
          fmask[ST_Z] = 1'b1; fval[ST_Z] = (res == '0);
        end
        OP_RL:  begin res = {b[DW-2:0], b[DW-1]}; we = 1'b1; end
        OP_RR:  begin res = {b[0], b[DW-1:1]};    we = 1'b1; end
        OP_RLC: begin
          res = {b[DW-2:0], c_in}; we = 1'b1;
          fmask[ST_C] = 1'b1; fval[ST_C] = b[DW-1];
        end
        OP_RRC: begin
          res = {c_in, b[DW-1:1]}; we = 1'b1;
          fmask[ST_C] = 1'b1; fval[ST_C] = b[0];
        end
        OP_SZ:  skip = (b == '0);
        OP_SNZ: skip = (b != '0);
        OP_SIZ: begin res = b_inc; we = 1'b1; skip = (b_inc == '0); end
        OP_SDZ: begin res = b_dec; we = 1'b1; skip = (b_dec == '0); end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/alu8_flagreg.sv
module alu8_flagreg
  import alu8_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_data,
  input  logic [LOW_FLAGS-1:0] upd_mask,
  input  logic [LOW_FLAGS-1:0] upd_val,
  input  logic                 wdt_ovf,
  input  logic                 wdt_clr,
  input  logic                 halt_ev,
  input  logic                 pwr_up,
  output logic [SW-1:0]        status
);
  logic [LOW_FLAGS-1:0] low_q, low_d;
  logic                 pdf_q, pdf_d, to_q, to_d;

  always_comb begin
    low_d = (low_q & ~upd_mask) | (upd_val & upd_mask);
    if (wr_en) low_d = wr_data[LOW_FLAGS-1:0];
    pdf_d = pdf_q;
    if (pwr_up || wdt_clr) pdf_d = 1'b0;
    else if (halt_ev)      pdf_d = 1'b1;
    to_d = to_q;
    if (pwr_up || wdt_clr || halt_ev) to_d = 1'b0;
    else if (wdt_ovf)                 to_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q <= '0;
      pdf_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      low_q <= low_d;
      pdf_q <= pdf_d;
      to_q  <= to_d;
    end
  end

  always_comb begin
    status               = '0;
    status[LOW_FLAGS-1:0] = low_q;
    status[ST_PDF]       = pdf_q;
    status[ST_TO]        = to_q;
  end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
  import alu8_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [4:0]     op_code,
  input  logic [7:0]     opnd_a,
  input  logic [7:0]     opnd_b,
  input  logic           st_wr_en,
  input  logic [7:0]     st_wr_data,
  input  logic           wdt_ovf,
  input  logic           wdt_clr,
  input  logic           halt_ev,
  input  logic           pwr_up,
  output logic [7:0]     result,
  output logic           result_we,
  output logic           skip,
  output logic [7:0]     status
);
  logic [LOW_FLAGS-1:0] flag_mask;
  logic [LOW_FLAGS-1:0] flag_val;

  alu8_core u_core (
    .op_valid (op_valid),
    .op_code  (op_code),
    .a        (opnd_a),
    .b        (opnd_b),
    .c_in     (status[ST_C]),
    .ac_in    (status[ST_AC]),
    .res      (result),
    .we       (result_we),
    .skip     (skip),
    .fmask    (flag_mask),
    .fval     (flag_val)
  );

  alu8_flagreg u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (st_wr_en),
    .wr_data  (st_wr_data),
    .upd_mask (flag_mask),
    .upd_val  (flag_val),
    .wdt_ovf  (wdt_ovf),
    .wdt_clr  (wdt_clr),
    .halt_ev  (halt_ev),
    .pwr_up   (pwr_up),
    .status   (status)
  );
endmodule

// File: rtl/alu8_status_chk.sv
module alu8_status_chk
  import alu8_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] op_code,
  input logic       st_wr_en,
  input logic       wdt_ovf,
  input logic       wdt_clr,
  input logic       halt_ev,
  input logic       pwr_up,
  input logic       result_we,
  input logic       skip,
  input logic [7:0] status
);
  // R1
  top_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[7:6] == 2'b00);

  // R9
  pdf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_ev && !pwr_up && !wdt_clr) |=> status[ST_PDF]);

  // R9
  pdf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt_ev && !pwr_up && !wdt_clr) |=> $stable(status[ST_PDF]));

  // R10
  to_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_ovf && !pwr_up && !wdt_clr && !halt_ev) |=> status[ST_TO]);

  // R10
  to_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_up || wdt_clr || halt_ev) |=> !status[ST_TO]);

  // R7
  skip_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (op_valid && op_code >= 5'd15 && op_code <= 5'd18));

  // R12
  test_skip_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 5'd15 || op_code == 5'd16)) |-> !result_we);

  // R11
  idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!op_valid || op_code > 5'd18) && !st_wr_en) |=> $stable(status[3:0]));

  // R11
  idle_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid || op_code > 5'd18) |-> (!result_we && !skip));

  // R6
  plain_rotate_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == 5'd9 || op_code == 5'd10) && !st_wr_en) |=> $stable(status[3:0]));
endmodule

bind alu8_status alu8_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .st_wr_en  (st_wr_en),
  .wdt_ovf   (wdt_ovf),
  .wdt_clr   (wdt_clr),
  .halt_ev   (halt_ev),
  .pwr_up    (pwr_up),
  .result_we (result_we),
  .skip      (skip),
  .status    (status)
);

// File: tb/alu8_status_bench.sv
module alu8_status_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0;
  logic       st_wr_en = 1'b0;
  logic [7:0] st_wr_data = '0;
  logic       wdt_ovf = 1'b0, wdt_clr = 1'b0, halt_ev = 1'b0, pwr_up = 1'b0;
  logic [7:0] result;
  logic       result_we, skip;
  logic [7:0] status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] m_st = 8'h00;

  always #4 clk = ~clk;

  alu8_status u_alu8_status (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .st_wr_en(st_wr_en), .st_wr_data(st_wr_data),
    .wdt_ovf(wdt_ovf), .wdt_clr(wdt_clr), .halt_ev(halt_ev), .pwr_up(pwr_up),
    .result(result), .result_we(result_we), .skip(skip), .status(status)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    if (op <= 1) return "R2";
    if (op <= 3) return "R3";
    if (op == 4) return "R4";
    if (op <= 8 || op == 13 || op == 14) return "R5";
    if (op <= 12) return "R6";
    if (op <= 18) return "R7";
    return "R11";
  endfunction

  function automatic int sgn(input int v);
    return (v >= 128) ? v - 256 : v;
  endfunction

  // Reference model written from the requirements.
  task automatic model(input bit v, input int op, input int a, input int b, input logic [7:0] st,
                       output int res, output bit we, output bit sk,
                       output logic [3:0] mask, output logic [3:0] val);
    int c, ac, s, t, u, sv;
    bit lo, hi;
    c = st[0]; ac = st[1];
    res = 0; we = 0; sk = 0; mask = 0; val = 0;
    if (!v || op > 18) return;
    we = 1;
    case (op)
      0, 1: begin
        s = a + b + ((op == 1) ? c : 0);
        sv = sgn(a) + sgn(b) + ((op == 1) ? c : 0);
        res = s & 255; mask = 4'hF;
        val = {sv > 127 || sv < -128, res == 0,
               ((a % 16) + (b % 16) + ((op == 1) ? c : 0)) > 15, s > 255};
      end
      2, 3: begin
        t = (op == 3) ? 1 - c : 0;
        s = a - b - t; sv = sgn(a) - sgn(b) - t;
        res = s & 255; mask = 4'hF;
        val = {sv > 127 || sv < -128, res == 0, ((a % 16) - (b % 16) - t) >= 0, s >= 0};
      end
      4: begin
        lo = ((a % 16) > 9) || ac;
        t = a + (lo ? 6 : 0);
        hi = (((t / 16) % 16) > 9) || c || (t > 255);
        u = t + (hi ? 96 : 0);
        res = u & 255; mask = 4'b0001; val = {3'b0, (c == 1) || (u > 255)};
      end
      5: res = a & b;
      6: res = a | b;
      7: res = a ^ b;
      8: res = 255 - b;
      13: res = (b + 1) & 255;
      14: res = (b + 255) & 255;
      9: res = ((b * 2) & 255) | (b / 128);
      10: res = (b / 2) | ((b % 2) * 128);
      11: begin res = ((b * 2) & 255) | c; mask = 4'b0001; val = {3'b0, b >= 128}; end
      12: begin res = (b / 2) | (c * 128); mask = 4'b0001; val = {3'b0, (b % 2) == 1}; end
      15: begin we = 0; sk = (b == 0); end
      16: begin we = 0; sk = (b != 0); end
      17: begin res = (b + 1) & 255; sk = (res == 0); end
      default: begin res = (b + 255) & 255; sk = (res == 0); end
    endcase
    if (op >= 5 && op <= 8 || op == 13 || op == 14) begin
      mask = 4'b0100; val = {1'b0, res == 0, 2'b0};
    end
  endtask

  task automatic cyc(input bit v, input int op, input int a, input int b,
                     input bit wr, input int wd,
                     input bit ovf, input bit clr, input bit hl, input bit pu);
    int er; bit ew, es; logic [3:0] mk, vl; logic [3:0] lo;
    @(negedge clk);
    op_valid = v; op_code = op[4:0]; opnd_a = a[7:0]; opnd_b = b[7:0];
    st_wr_en = wr; st_wr_data = wd[7:0];
    wdt_ovf = ovf; wdt_clr = clr; halt_ev = hl; pwr_up = pu;
    #1;
    model(v, op, a, b, m_st, er, ew, es, mk, vl);
    chk({req_of(op), " R12 write strobe"}, int'(result_we), int'(ew));
    chk({req_of(op), " skip"}, int'(skip), int'(es));
    if (ew) chk({req_of(op), " result"}, int'(result), er);
    lo = (m_st[3:0] & ~mk) | (vl & mk);
    if (wr) lo = wd[3:0];
    m_st[3:0] = lo;
    if (pu || clr) m_st[4] = 1'b0; else if (hl) m_st[4] = 1'b1;
    if (pu || clr || hl) m_st[5] = 1'b0; else if (ovf) m_st[5] = 1'b1;
    @(posedge clk);
    #1;
    if (wr) chk("R8 status after write", int'(status), int'(m_st));
    else if (ovf || clr || hl || pu) chk("R9 R10 status after event", int'(status), int'(m_st));
    else chk({req_of(op), " R1 status flags"}, int'(status), int'(m_st));
  endtask

  task automatic op1(input int op, input int a, input int b);
    cyc(1'b1, op, a, b, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic wst(input int d);
    cyc(1'b0, 0, 0, 0, 1'b1, d, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic ev(input bit ovf, input bit clr, input bit hl, input bit pu);
    cyc(1'b0, 0, 0, 0, 1'b0, 0, ovf, clr, hl, pu);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset status", int'(status), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2 carry, half carry, zero, signed overflow
    op1(0, 8'hFF, 8'h01);
    op1(1, 8'h0F, 8'h00);
    op1(0, 8'h7F, 8'h01);
    // R3 borrow conventions
    op1(2, 8'h05, 8'h05);
    op1(2, 8'h03, 8'h05);
    op1(3, 8'h80, 8'h01);
    op1(3, 8'h10, 8'h01);
    // R4 decimal adjust corners
    op1(0, 8'h09, 8'h01); op1(4, 8'h0A, 0);
    op1(0, 8'h99, 8'h01); op1(4, 8'h9A, 0);
    op1(0, 8'h58, 8'h48); op1(4, 8'hA0, 0);
    // R5 logic / inc / dec
    op1(5, 8'hF0, 8'h0F); op1(6, 8'h00, 8'h00); op1(7, 8'hAA, 8'h55);
    op1(8, 0, 8'hFF); op1(13, 0, 8'hFF); op1(14, 0, 8'h01);
    // R6 rotates
    op1(9, 0, 8'h81); op1(10, 0, 8'h01); op1(11, 0, 8'h80); op1(11, 0, 8'h00); op1(12, 0, 8'h01);
    // R7 skips
    op1(15, 0, 0); op1(15, 0, 1); op1(16, 0, 0); op1(16, 0, 7);
    op1(17, 0, 8'hFF); op1(17, 0, 8'h10); op1(18, 0, 8'h01); op1(18, 0, 8'h00);
    // R8 write protects bits 4/5 and beats a same-cycle op
    ev(1'b1, 1'b0, 1'b0, 1'b0);
    wst(8'hFF);
    wst(8'h00);
    cyc(1'b1, 0, 8'hFF, 8'h01, 1'b1, 8'h08, 1'b0, 1'b0, 1'b0, 1'b0);
    // R9 / R10 event priorities
    ev(1'b0, 1'b0, 1'b1, 1'b0);
    ev(1'b1, 1'b0, 1'b1, 1'b0);
    ev(1'b1, 1'b0, 1'b0, 1'b0);
    ev(1'b1, 1'b1, 1'b1, 1'b0);
    ev(1'b0, 1'b0, 1'b1, 1'b0);
    ev(1'b1, 1'b0, 1'b0, 1'b1);
    // R11 idle and undefined codes
    wst(8'h0F);
    cyc(1'b0, 0, 8'hFF, 8'hFF, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0);
    op1(19, 8'h12, 8'h34); op1(31, 0, 0);

    for (int i = 0; i < 3000; i++) begin
      int op, a, b, r;
      bit wr, ovf, clr, hl, pu;
      op = $urandom_range(0, 21);
      a = $urandom_range(0, 255);
      b = $urandom_range(0, 255);
      if ($urandom_range(0, 7) == 0) b = (b % 3 == 0) ? 0 : ((b % 3 == 1) ? 255 : 1);
      r = $urandom_range(0, 99);
      wr = (r < 6); ovf = (r >= 90); clr = (r == 50); hl = (r >= 80 && r < 88); pu = (r == 51);
      cyc($urandom_range(0, 9) != 0, op, a, b, wr, $urandom_range(0, 255), ovf, clr, hl, pu);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule